// File: doc/BRIEF.md
# Sector Write-Protection Arbiter

This block is the gatekeeper in front of a flash-style sector array. Each program or erase request names one sector. One cycle after the request, the block answers with either a grant pulse or a reject pulse. Several protection sources must all be clear before it grants:

- a supply-low flag;
- a global lock pin;
- a range check on the sector index;
- a write-protect pin that guards the two outermost boot sectors;
- a per-sector lock bit array;
- a persistent protect bit for each of the two boot sectors.

The boot configuration input selects which end of the array holds the boot pair.

Commands arrive on a separate command port. They lock or unlock a sector, or set or clear the persistent protection of a boot sector. A change takes effect for requests from the next cycle onward. The hardware reset clears the per-sector locks and keeps the boot protection bits. Only the power-on reset clears the boot protection bits.

The control is a three-state machine:

- `ST_IDLE`: no answer is being given.
- `ST_GRANT`: drives `grant`.
- `ST_REJECT`: drives `reject`.

Transitions:

- Any state goes to `ST_GRANT` when a request arrives and nothing blocks its sector.
- Any state goes to `ST_REJECT` when a request arrives and some source blocks its sector.
- Any state goes to `ST_IDLE` when no request arrives.
- Reset forces `ST_IDLE`.

Top module: `sect_prot_arb`

## Requirements
- R1: A request sampled at a rising edge produces, in the following cycle, exactly one of `grant` or `reject` high for one cycle. With no request, both stay low. Both are low out of reset.
- R2: While `supply_low` is 1, every request is rejected and every command is ignored.
- R3: While `all_lock_n` is 0, every request is rejected.
- R4: A sector index above 133 is always rejected, and commands naming such an index are ignored.
- R5: A command with `cmd_op`=2'b00 locks `cmd_sector`, after which requests to that sector are rejected. A command with `cmd_op`=2'b01 unlocks it again.
- R6: With `top_boot`=0 the boot pair is sectors 0 and 1. With `top_boot`=1 it is sectors 132 and 133. While `hold_boot_n` is 0, requests to the boot pair are rejected.
- R7: While `hold_boot_n` is 1, each boot sector is rejected exactly when its persistent bit is set. `cmd_op`=2'b10 sets the bit and 2'b11 clears it. The lower-numbered sector of the pair uses bit 0. Set/clear commands naming a non-boot sector are ignored.
- R8: `rst_n` low clears every per-sector lock and keeps the boot protection bits. `por_n` low clears the boot protection bits.
- R9: A request and a command in the same cycle: the request is judged on the state before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset for boot protection bits, active low |
| req_valid | input | 1 | Program/erase request strobe |
| req_sector | input | 8 | Sector index of the request |
| hold_boot_n | input | 1 | Boot-pair write protect, active low |
| all_lock_n | input | 1 | Global lock, active low |
| top_boot | input | 1 | 1 = boot pair at top of array, 0 = bottom |
| supply_low | input | 1 | Supply below lockout threshold |
| cmd_valid | input | 1 | Protection command strobe |
| cmd_op | input | 2 | 00 lock, 01 unlock, 10 boot protect, 11 boot unprotect |
| cmd_sector | input | 8 | Sector named by the command |
| grant | output | 1 | One-cycle grant pulse |
| reject | output | 1 | One-cycle reject pulse |

## Verification
Random requests are drawn from four sector pools: the four possible boot sectors, the out-of-range indices, the whole array, and a small low-index cluster where locks pile up. This separates which blocking source decided each answer. The protection pins and the boot configuration are toggled at random, so the same boot-sector request sees both pair placements and both settings of the write-protect pin. That distinguishes a wrong pair mapping from a wrong fallback to the persistent bits. Directed sequences cover the cases random stimulus reaches rarely:

- a lock and a request to the same sector in the same cycle;
- a hardware reset that must forget locks but remember boot protection;
- a power-on reset that forgets both.

// File: rtl/sect_prot_pkg.sv
package sect_prot_pkg;

    localparam int NUM_SECTORS = 134;
    localparam int SECT_W      = $clog2(NUM_SECTORS + 1);

    typedef enum logic [1:0] {
        OP_LOCK     = 2'b00,
        OP_UNLOCK   = 2'b01,
        OP_BOOT_SET = 2'b10,
        OP_BOOT_CLR = 2'b11
    } prot_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_GRANT  = 2'b01,
        ST_REJECT = 2'b10
    } arb_state_e;

    // One flag per independent blocking source
    typedef struct packed {
        logic supply;
        logic accel;
        logic range;
        logic boot;
        logic lock;
    } block_why_t;

endpackage

// File: rtl/boot_sector_map.sv
module boot_sector_map #(
    parameter int NUM_SECTORS = 134,
    parameter int SECT_W      = 8
) (
    input  logic [SECT_W-1:0] sector,
    input  logic              top_boot,
    output logic              is_boot,
    output logic              boot_idx
);
    localparam logic [SECT_W-1:0] TOP_BASE = SECT_W'(NUM_SECTORS - 2);

    logic [SECT_W-1:0] base;
    logic [SECT_W-1:0] base_p1;

    assign base     = top_boot ? TOP_BASE : '0;
    assign base_p1  = base + 1'b1;
    assign is_boot  = (sector == base) || (sector == base_p1);
    // bit 0 belongs to the lower-numbered sector of the pair
    assign boot_idx = (sector == base_p1);
endmodule

// File: rtl/sector_lock_bank.sv
module sector_lock_bank #(
    parameter int NUM_SECTORS = 134,
    parameter int SECT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SECT_W-1:0] wr_sector,
    input  logic              wr_lock,
    input  logic [SECT_W-1:0] rd_sector,
    output logic              rd_locked
);
    localparam logic [SECT_W-1:0] LAST = SECT_W'(NUM_SECTORS - 1);

    logic [NUM_SECTORS-1:0] lock_q;

    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
        localparam logic [SECT_W-1:0] IDX = SECT_W'(i);
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (wr_en && (wr_sector == IDX)) begin
                bit_q <= wr_lock;
            end
        end
        assign lock_q[i] = bit_q;
    end

    always_comb begin
        rd_locked = 1'b0;
        if (rd_sector <= LAST) begin
            rd_locked = lock_q[rd_sector];
        end
    end
endmodule

// File: rtl/boot_prot_store.sv
module boot_prot_store (
    input  logic       clk,
    input  logic       por_n,
    input  logic       wr_en,
    input  logic       wr_idx,
    input  logic       wr_val,
    output logic [1:0] prot_q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            prot_q <= 2'b00;
        end else if (wr_en) begin
            prot_q[wr_idx] <= wr_val;
        end
    end
endmodule

// File: rtl/sect_prot_arb.sv
module sect_prot_arb
    import sect_prot_pkg::*;
#(
    parameter int NSECT = NUM_SECTORS,
    parameter int SW    = SECT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          req_valid,
    input  logic [SW-1:0] req_sector,
    input  logic          hold_boot_n,
    input  logic          all_lock_n,
    input  logic          top_boot,
    input  logic          supply_low,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [SW-1:0] cmd_sector,
    output logic          grant,
    output logic          reject
);
    localparam logic [SW-1:0] LAST = SW'(NSECT - 1);

    arb_state_e state_q, state_d;
    prot_op_e   op;
    block_why_t why;
    logic       blocked;

    logic       req_is_boot, req_boot_idx, req_locked;
    logic       cmd_is_boot, cmd_boot_idx, cmd_live;
    logic       lock_wr, lock_val, boot_wr, boot_val;
    logic [1:0] boot_prot;

    assign op = prot_op_e'(cmd_op);

    // ---------------- command decode ----------------
    assign cmd_live = cmd_valid && rst_n && !supply_low && (cmd_sector <= LAST);
    assign lock_wr  = cmd_live && ((op == OP_LOCK) || (op == OP_UNLOCK));
    assign lock_val = (op == OP_LOCK);
    assign boot_wr  = cmd_live && cmd_is_boot &&
                      ((op == OP_BOOT_SET) || (op == OP_BOOT_CLR));
    assign boot_val = (op == OP_BOOT_SET);

    boot_sector_map #(.NUM_SECTORS(NSECT), .SECT_W(SW)) u_req_map (
        .sector   (req_sector),
        .top_boot (top_boot),
        .is_boot  (req_is_boot),
        .boot_idx (req_boot_idx)
    );

    boot_sector_map #(.NUM_SECTORS(NSECT), .SECT_W(SW)) u_cmd_map (
        .sector   (cmd_sector),
        .top_boot (top_boot),
        .is_boot  (cmd_is_boot),
        .boot_idx (cmd_boot_idx)
    );

    sector_lock_bank #(.NUM_SECTORS(NSECT), .SECT_W(SW)) u_locks (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (lock_wr),
        .wr_sector (cmd_sector),
        .wr_lock   (lock_val),
        .rd_sector (req_sector),
        .rd_locked (req_locked)
    );

    boot_prot_store u_boot (
        .clk    (clk),
        .por_n  (por_n),
        .wr_en  (boot_wr),
        .wr_idx (cmd_boot_idx),
        .wr_val (boot_val),
        .prot_q (boot_prot)
    );

    // ---------------- protection combine ----------------
    always_comb begin
        why.supply = supply_low;
        why.accel  = !all_lock_n;
        why.range  = (req_sector > LAST);
        why.boot   = req_is_boot && (!hold_boot_n || boot_prot[req_boot_idx]);
        why.lock   = req_locked;
        blocked    = |why;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_GRANT, ST_REJECT: begin
                if (req_valid) begin
                    state_d = blocked ? ST_REJECT : ST_GRANT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        grant  = (state_q == ST_GRANT);
        reject = (state_q == ST_REJECT);
    end
endmodule

// File: rtl/sect_prot_arb_chk.sv
module sect_prot_arb_chk #(
    parameter int NSECT = 134,
    parameter int SW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [SW-1:0] req_sector,
    input logic          hold_boot_n,
    input logic          all_lock_n,
    input logic          top_boot,
    input logic          supply_low,
    input logic          grant,
    input logic          reject
);
    localparam logic [SW-1:0] LAST     = SW'(NSECT - 1);
    localparam logic [SW-1:0] TOP_BASE = SW'(NSECT - 2);

    logic in_pair;
    assign in_pair = top_boot ? (req_sector >= TOP_BASE && req_sector <= LAST)
                              : (req_sector <= SW'(1));

    // R1
    grant_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && reject));

    // R1
    req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant || reject));

    // R1
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(grant || reject));

    // R2
    low_supply_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && supply_low) |=> reject);

    // R3
    all_locked_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !all_lock_n) |=> reject);

    // R4
    range_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sector > LAST) |=> reject);

    // R6
    boot_hold_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hold_boot_n && in_pair) |=> reject);
endmodule

bind sect_prot_arb sect_prot_arb_chk #(.NSECT(NSECT), .SW(SW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_sector  (req_sector),
    .hold_boot_n (hold_boot_n),
    .all_lock_n  (all_lock_n),
    .top_boot    (top_boot),
    .supply_low  (supply_low),
    .grant       (grant),
    .reject      (reject)
);

// File: tb/tb_sect_prot_arb.sv
module tb_sect_prot_arb;
    localparam int NS = 134;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, por_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_sector = '0;
    logic       hold_boot_n = 1'b1, all_lock_n = 1'b1, top_boot = 1'b0, supply_low = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [7:0] cmd_sector = '0;
    logic       grant, reject;

    int checks = 0, failures = 0;
    bit lock_m [NS];
    bit [1:0] boot_m;
    string tag_ovr = "";

    always #2 clk = ~clk;

    sect_prot_arb dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .req_valid(req_valid), .req_sector(req_sector),
        .hold_boot_n(hold_boot_n), .all_lock_n(all_lock_n),
        .top_boot(top_boot), .supply_low(supply_low),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sector(cmd_sector),
        .grant(grant), .reject(reject)
    );

    function automatic bit boot_of(input int s, input bit top, output bit idx);
        int base = top ? NS - 2 : 0;
        idx = (s == base + 1);
        return (s == base) || (s == base + 1);
    endfunction

    function automatic bit exp_reject(input int s, output string tag);
        bit idx, isb;
        isb = boot_of(s, top_boot, idx);
        if (supply_low)                         begin tag = "R2"; return 1; end
        if (!all_lock_n)                        begin tag = "R3"; return 1; end
        if (s > NS - 1)                         begin tag = "R4"; return 1; end
        if (isb && !hold_boot_n)                begin tag = "R6"; return 1; end
        if (isb && boot_m[idx])                 begin tag = "R7"; return 1; end
        if (lock_m[s])                          begin tag = "R5"; return 1; end
        tag = "R1";
        return 0;
    endfunction

    task automatic check(input string tag, input bit g, input bit r);
        checks++;
        if (grant !== g || reject !== r) begin
            failures++;
            $display("FAIL %s: grant/reject actual=%b%b expected=%b%b", tag, grant, reject, g, r);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic step(input bit rq, input int sec, input bit cv, input bit [1:0] op, input int csec);
        bit er, idx;
        string tg;
        req_valid  = rq;
        req_sector = 8'(sec);
        cmd_valid  = cv;
        cmd_op     = op;
        cmd_sector = 8'(csec);
        er = exp_reject(sec, tg);
        @(posedge clk);
        if (cv && !supply_low && csec <= NS - 1) begin
            if (op == 2'b00) lock_m[csec] = 1;
            else if (op == 2'b01) lock_m[csec] = 0;
            else if (boot_of(csec, top_boot, idx)) boot_m[idx] = (op == 2'b10);
        end
        @(negedge clk);
        req_valid = 1'b0;
        cmd_valid = 1'b0;
        if (tag_ovr != "") tg = tag_ovr;
        if (rq) check(tg, !er, er);
        else    check("R1", 1'b0, 1'b0);
    endtask

    task automatic do_reset(input bit por);
        req_valid = 0; cmd_valid = 0;
        rst_n = 0;
        if (por) por_n = 0;
        repeat (2) @(negedge clk);
        foreach (lock_m[i]) lock_m[i] = 0;
        if (por) boot_m = 2'b00;
        rst_n = 1; por_n = 1;
        @(negedge clk);
        check("R8", 1'b0, 1'b0);
    endtask

    function automatic int pick_sector();
        case ($urandom % 4)
            0: begin
                int v = $urandom % 4;
                return (v < 2) ? v : NS - 4 + v;
            end
            1: return NS + ($urandom % (256 - NS));
            2: return $urandom % NS;
            default: return $urandom % 8;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (lock_m[i]) lock_m[i] = 0;
        boot_m = 2'b00;
        @(negedge clk);
        @(negedge clk);
        check("R1", 1'b0, 1'b0);          // reset state
        rst_n = 1; por_n = 1;
        @(negedge clk);

        // R1 idle: no request, no pulse
        step(0, 5, 0, 2'b00, 0);
        step(1, 40, 0, 2'b00, 0);         // plain grant
        // R5 lock then unlock
        step(0, 0, 1, 2'b00, 40);
        step(1, 40, 0, 2'b00, 0);
        step(0, 0, 1, 2'b01, 40);
        step(1, 40, 0, 2'b00, 0);
        // R9 lock and request in the same cycle: old state wins
        tag_ovr = "R9";
        step(1, 7, 1, 2'b00, 7);
        step(1, 7, 1, 2'b01, 7);
        step(1, 7, 0, 2'b00, 0);
        tag_ovr = "";
        // R6 boot pair placement under write protect
        hold_boot_n = 0;
        step(1, 1, 0, 2'b00, 0);
        step(1, 132, 0, 2'b00, 0);
        top_boot = 1;
        step(1, 133, 0, 2'b00, 0);
        step(1, 1, 0, 2'b00, 0);
        hold_boot_n = 1;
        // R7 persistent bits; command on non-boot sector ignored
        step(0, 0, 1, 2'b10, 133);
        step(1, 133, 0, 2'b00, 0);
        step(1, 132, 1, 2'b10, 50);
        step(1, 50, 0, 2'b00, 0);
        // R2 command ignored at low supply
        supply_low = 1;
        step(1, 60, 1, 2'b00, 60);
        supply_low = 0;
        step(1, 60, 0, 2'b00, 0);
        // R4 out-of-range request and command
        step(1, 134, 1, 2'b00, 200);
        step(1, 255, 0, 2'b00, 0);
        // R3
        all_lock_n = 0;
        step(1, 60, 0, 2'b00, 0);
        all_lock_n = 1;
        // R8 hardware reset keeps boot bits, clears locks
        top_boot = 0;
        step(0, 0, 1, 2'b10, 0);
        step(0, 0, 1, 2'b00, 9);
        do_reset(0);
        tag_ovr = "R8";
        step(1, 9, 0, 2'b00, 0);
        step(1, 0, 0, 2'b00, 0);
        do_reset(1);
        step(1, 0, 0, 2'b00, 0);
        tag_ovr = "";

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            supply_low  = ($urandom % 16) == 0;
            all_lock_n  = ($urandom % 12) != 0;
            hold_boot_n = ($urandom % 4) != 0;
            if ($urandom % 8 == 0) top_boot = ~top_boot;
            if ($urandom % 600 == 0) do_reset(($urandom % 3) == 0);
            step(($urandom % 4) != 0, pick_sector(), ($urandom % 3) == 0,
                 2'($urandom), pick_sector());
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule